// File: doc/BRIEF.md
# Automatic Sound Mode Selector

This block is the control core that sits behind a television sound demodulator and decides, from identification flags, which broadcast sound mode is on air. It keeps the active standard, settles the mode (mono, stereo or two languages), chooses between the digital sound carrier and the analog mono carrier, and lays the demodulated audio words out on four fixed source channels. A downstream source selector can then pick one of these channels and keep its output matrix at plain stereo, because every mode-dependent swap of left, right, language A and language B is done here.

The block also hunts on its own. In the two standards that share one FM mono carrier (a dual-FM standard and an FM-plus-digital standard), it alternates between them at a fixed dwell time while no identification is present, so that whichever signalling the station uses gets found. It stops as soon as a mode is identified or digital sound is in use. Digital sound falls back to analog mono when its error rate is too high or the digital carrier is lost, and it comes back only after a quiet period below a lower threshold. A lost FM carrier mutes the matching analog input. A status word reports the state, and any change in it gives a one-cycle pulse.

Evaluation happens on `tick`, a single-cycle strobe at the rate the identification logic updates. Audio words pass through as opaque samples.

Top module: `snd_auto_select`

## Requirements
- R1: Four source channels are driven: code 0 on `src0_*`, code 1 on `src1_*`, code 3 on `src3_*`, code 4 on `src4_*`. In the dual-FM standard (code 1 on `std_sel`) stereo puts primary on the left and secondary on the right of every channel; in two-language mode channels 0 and 1 carry A left and B right, channel 3 carries A on both sides and channel 4 carries B on both sides; mono puts the primary word on all sides.
- R2: In the FM-plus-digital standard (code 2) channel 0 always carries the analog primary word on both sides, whatever the mode or the digital state.
- R3: In standards 1 and 2, while no mode other than mono is accepted and digital sound is not in use, the block swaps to the partner standard (1 to 2, 2 to 1) on the DWELL-th tick counted from the load or the last swap, and `hop_req` is high for the one cycle after the swap.
- R4: Once a stereo or two-language mode is accepted, or digital sound is in use, the standard stays fixed.
- R5: A mode is accepted only after the same identification value is seen on ID_STABLE consecutive ticks. Identification is two-language when `id_bilingual` is set, else stereo when `id_stereo` is set, else mono.
- R6: While digital sound is in use in standard 2, a tick with `dig_ok` low or `dig_err` greater than ERR_HI switches channels 1, 3 and 4 to analog mono; `dig_err` equal to ERR_HI keeps digital sound.
- R7: Digital sound is taken up only after RECOVER consecutive ticks with `dig_ok` high and `dig_err` below ERR_LO; a tick at or above ERR_LO restarts that count. With digital sound in use, mono gives digital A on all sides, stereo gives A left and B right, two-language gives A/B on channel 1, A/A on channel 3 and B/B on channel 4.
- R8: In the pilot standard (code 3) `id_bilingual` is ignored; all four channels carry primary/secondary when stereo is accepted and primary on both sides otherwise.
- R9: In the pilot standard, once `sap_det` is seen on a tick, channel 1 carries primary left and the second program right, and channel 4 carries the second program on both sides.
- R10: When `carrier_ok[0]` is low the primary word is replaced by zero on every output, and when `carrier_ok[1]` is low the secondary word is replaced by zero.
- R11: `status` is registered: bits 1:0 standard, bits 3:2 accepted mode (0 mono, 1 stereo, 2 two-language), bit 4 digital in use, bit 5 second program seen, bit 6 primary muted, bit 7 secondary muted. `status_irq` is high for exactly the cycle in which `status` shows a new value.
- R12: In the mono standard (code 0) all channels carry the primary word on both sides; `std_load` sets the standard from `std_sel` and clears the accepted mode, the digital state and the second-program flag.
- R13: After reset the standard is 0, `status` is 0 with both carriers present, and `hop_req` and `status_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Evaluation strobe, one cycle wide |
| std_load | input | 1 | Load `std_sel` as the active standard |
| std_sel | input | 2 | Standard code: 0 mono, 1 dual-FM, 2 FM-plus-digital, 3 pilot |
| id_stereo | input | 1 | Stereo identification (pilot present in standard 3) |
| id_bilingual | input | 1 | Two-language identification |
| dig_ok | input | 1 | Digital sound carrier received |
| dig_err | input | ERR_W | Digital error-rate value |
| sap_det | input | 1 | Second audio program carrier detected |
| carrier_ok | input | 2 | FM carrier present, bit 0 primary, bit 1 secondary |
| pri_smp | input | SMP_W | Analog primary word (mono, left or language A) |
| sec_smp | input | SMP_W | Analog secondary word (right or language B) |
| sap_smp | input | SMP_W | Second audio program word |
| dga_smp | input | SMP_W | Digital word A |
| dgb_smp | input | SMP_W | Digital word B |
| src0_l | output | SMP_W | Channel code 0, left |
| src0_r | output | SMP_W | Channel code 0, right |
| src1_l | output | SMP_W | Channel code 1, left |
| src1_r | output | SMP_W | Channel code 1, right |
| src3_l | output | SMP_W | Channel code 3, left |
| src3_r | output | SMP_W | Channel code 3, right |
| src4_l | output | SMP_W | Channel code 4, left |
| src4_r | output | SMP_W | Channel code 4, right |
| cur_std | output | 2 | Active standard |
| status | output | 8 | Status word |
| status_irq | output | 1 | One-cycle pulse on any status change |
| hop_req | output | 1 | One-cycle request for a quiet swap of standards |

## Verification
The properties take `tick` to be a pulse that never stays high for two cycles and `std_load` to be a pulse, and they assume every `std_sel` value is one of the four defined codes, which a two-bit field guarantees. They also assume the audio words are free to change every cycle while the control inputs change only between ticks. The stimulus drives all inputs on the falling edge, raises `tick` and `std_load` for single cycles with gaps, redraws the audio words and carrier flags at random between ticks, and walks the error rate across both thresholds and exactly onto them.

// File: rtl/snd_sel_pkg.sv
package snd_sel_pkg;

    typedef enum logic [1:0] {
        STD_MONO  = 2'd0,
        STD_DUAL  = 2'd1,
        STD_DIGI  = 2'd2,
        STD_PILOT = 2'd3
    } std_e;

    typedef enum logic [1:0] {
        MD_MONO   = 2'd0,
        MD_STEREO = 2'd1,
        MD_BILING = 2'd2
    } mode_e;

    typedef struct packed {
        logic  mute_sec;
        logic  mute_pri;
        logic  sap;
        logic  dig;
        mode_e mode;
        std_e  std;
    } stat_t;

    localparam int unsigned NUM_SRC = 4;

    function automatic logic is_pair(std_e s);
        return (s == STD_DUAL) || (s == STD_DIGI);
    endfunction

    function automatic std_e partner(std_e s);
        return (s == STD_DUAL) ? STD_DIGI : STD_DUAL;
    endfunction

    function automatic mode_e id_to_mode(std_e s, logic st, logic bil);
        if (bil && (s != STD_PILOT)) return MD_BILING;
        if (st) return MD_STEREO;
        return MD_MONO;
    endfunction

endpackage

// File: rtl/snd_id_filter.sv
module snd_id_filter
    import snd_sel_pkg::*;
#(
    parameter int unsigned ID_STABLE = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  tick,
    input  mode_e samp,
    output mode_e acc
);
    localparam int unsigned CW = $clog2(ID_STABLE + 1);
    localparam logic [CW-1:0] CMAX = CW'(ID_STABLE);

    mode_e         prev;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    always_comb begin
        if (samp != prev)      cnt_n = CW'(1);
        else if (cnt == CMAX)  cnt_n = cnt;
        else                   cnt_n = cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev <= MD_MONO;
            cnt  <= '0;
            acc  <= MD_MONO;
        end else if (tick) begin
            prev <= samp;
            cnt  <= cnt_n;
            if (cnt_n >= CMAX) acc <= samp;
        end
    end
endmodule

// File: rtl/snd_dig_fallback.sv
module snd_dig_fallback #(
    parameter int unsigned       ERR_W   = 8,
    parameter logic [ERR_W-1:0]  ERR_HI  = 8'd100,
    parameter logic [ERR_W-1:0]  ERR_LO  = 8'd40,
    parameter int unsigned       RECOVER = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic             en,
    input  logic             dig_ok,
    input  logic [ERR_W-1:0] err,
    output logic             dig_use
);
    localparam int unsigned   RC_W    = $clog2(RECOVER + 1);
    localparam logic [RC_W-1:0] RC_LAST = RC_W'(RECOVER - 1);

    logic [RC_W-1:0] good;
    logic            bad_now;
    logic            clean_now;

    assign bad_now   = !dig_ok || (err > ERR_HI);
    assign clean_now = dig_ok && (err < ERR_LO);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            dig_use <= 1'b0;
            good    <= '0;
        end else if (tick && en) begin
            if (dig_use) begin
                if (bad_now) begin
                    dig_use <= 1'b0;
                    good    <= '0;
                end
            end else if (clean_now) begin
                if (good == RC_LAST) begin
                    dig_use <= 1'b1;
                    good    <= '0;
                end else begin
                    good <= good + 1'b1;
                end
            end else begin
                good <= '0;
            end
        end
    end
endmodule

// File: rtl/snd_hunt.sv
module snd_hunt
    import snd_sel_pkg::*;
#(
    parameter int unsigned DWELL = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic load,
    input  std_e load_std,
    input  logic hold,
    output std_e cur,
    output logic swap,
    output logic hop_req
);
    localparam int unsigned DW_W = $clog2(DWELL + 1);
    localparam logic [DW_W-1:0] DW_LAST = DW_W'(DWELL - 1);

    logic [DW_W-1:0] dwell;
    logic            hunting;

    assign hunting = is_pair(cur) && !hold;
    assign swap    = !load && tick && hunting && (dwell == DW_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= STD_MONO;
            dwell   <= '0;
            hop_req <= 1'b0;
        end else begin
            hop_req <= swap;
            if (load) begin
                cur   <= load_std;
                dwell <= '0;
            end else if (!hunting) begin
                dwell <= '0;
            end else if (tick) begin
                if (swap) begin
                    cur   <= partner(cur);
                    dwell <= '0;
                end else begin
                    dwell <= dwell + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/snd_router.sv
module snd_router
    import snd_sel_pkg::*;
#(
    parameter int unsigned SMP_W = 16
) (
    input  std_e                             std,
    input  mode_e                            mode,
    input  logic                             dig_use,
    input  logic                             sap_on,
    input  logic [1:0]                       carrier_ok,
    input  logic [SMP_W-1:0]                 pri,
    input  logic [SMP_W-1:0]                 sec,
    input  logic [SMP_W-1:0]                 sap,
    input  logic [SMP_W-1:0]                 dga,
    input  logic [SMP_W-1:0]                 dgb,
    output logic [NUM_SRC-1:0][SMP_W-1:0]    out_l,
    output logic [NUM_SRC-1:0][SMP_W-1:0]    out_r
);
    logic [1:0][SMP_W-1:0] an_raw;
    logic [1:0][SMP_W-1:0] an;

    assign an_raw[0] = pri;
    assign an_raw[1] = sec;

    for (genvar g = 0; g < 2; g++) begin : g_mute
        assign an[g] = carrier_ok[g] ? an_raw[g] : '0;
    end

    // index 0..3 hold channel codes 0, 1, 3, 4
    always_comb begin
        for (int k = 0; k < NUM_SRC; k++) begin
            out_l[k] = an[0];
            out_r[k] = an[0];
        end
        unique case (std)
            STD_DUAL: begin
                if (mode == MD_STEREO) begin
                    for (int k = 0; k < NUM_SRC; k++) out_r[k] = an[1];
                end else if (mode == MD_BILING) begin
                    out_r[0] = an[1];
                    out_r[1] = an[1];
                    out_l[3] = an[1];
                    out_r[3] = an[1];
                end
            end
            STD_DIGI: begin
                if (dig_use) begin
                    for (int k = 1; k < NUM_SRC; k++) begin
                        out_l[k] = dga;
                        out_r[k] = (mode == MD_STEREO) ? dgb : dga;
                    end
                    if (mode == MD_BILING) begin
                        out_r[1] = dgb;
                        out_l[3] = dgb;
                        out_r[3] = dgb;
                    end
                end
            end
            STD_PILOT: begin
                if (mode == MD_STEREO) begin
                    for (int k = 0; k < NUM_SRC; k++) out_r[k] = an[1];
                end
                if (sap_on) begin
                    out_r[1] = sap;
                    out_l[3] = sap;
                    out_r[3] = sap;
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/snd_auto_select.sv
module snd_auto_select
    import snd_sel_pkg::*;
#(
    parameter int unsigned      SMP_W     = 16,
    parameter int unsigned      ERR_W     = 8,
    parameter logic [ERR_W-1:0] ERR_HI    = 8'd100,
    parameter logic [ERR_W-1:0] ERR_LO    = 8'd40,
    parameter int unsigned      RECOVER   = 4,
    parameter int unsigned      DWELL     = 6,
    parameter int unsigned      ID_STABLE = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             std_load,
    input  logic [1:0]       std_sel,
    input  logic             id_stereo,
    input  logic             id_bilingual,
    input  logic             dig_ok,
    input  logic [ERR_W-1:0] dig_err,
    input  logic             sap_det,
    input  logic [1:0]       carrier_ok,
    input  logic [SMP_W-1:0] pri_smp,
    input  logic [SMP_W-1:0] sec_smp,
    input  logic [SMP_W-1:0] sap_smp,
    input  logic [SMP_W-1:0] dga_smp,
    input  logic [SMP_W-1:0] dgb_smp,
    output logic [SMP_W-1:0] src0_l,
    output logic [SMP_W-1:0] src0_r,
    output logic [SMP_W-1:0] src1_l,
    output logic [SMP_W-1:0] src1_r,
    output logic [SMP_W-1:0] src3_l,
    output logic [SMP_W-1:0] src3_r,
    output logic [SMP_W-1:0] src4_l,
    output logic [SMP_W-1:0] src4_r,
    output logic [1:0]       cur_std,
    output logic [7:0]       status,
    output logic             status_irq,
    output logic             hop_req
);
    std_e  std_q;
    mode_e mode_acc;
    mode_e mode_samp;
    logic  swap;
    logic  std_chg;
    logic  dig_use;
    logic  sap_q;
    logic  hold;
    stat_t stat_n;
    stat_t stat_q;

    logic [NUM_SRC-1:0][SMP_W-1:0] rl;
    logic [NUM_SRC-1:0][SMP_W-1:0] rr;

    assign mode_samp = id_to_mode(std_q, id_stereo, id_bilingual);
    assign hold      = (mode_acc != MD_MONO) || dig_use;
    assign std_chg   = std_load || swap;

    snd_hunt #(.DWELL(DWELL)) u_hunt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .load     (std_load),
        .load_std (std_e'(std_sel)),
        .hold     (hold),
        .cur      (std_q),
        .swap     (swap),
        .hop_req  (hop_req)
    );

    snd_id_filter #(.ID_STABLE(ID_STABLE)) u_id (
        .clk  (clk),
        .rst  (rst),
        .clr  (std_chg),
        .tick (tick),
        .samp (mode_samp),
        .acc  (mode_acc)
    );

    snd_dig_fallback #(
        .ERR_W   (ERR_W),
        .ERR_HI  (ERR_HI),
        .ERR_LO  (ERR_LO),
        .RECOVER (RECOVER)
    ) u_fb (
        .clk     (clk),
        .rst     (rst),
        .clr     (std_chg),
        .tick    (tick),
        .en      (std_q == STD_DIGI),
        .dig_ok  (dig_ok),
        .err     (dig_err),
        .dig_use (dig_use)
    );

    always_ff @(posedge clk) begin
        if (rst || std_chg) sap_q <= 1'b0;
        else if (tick)      sap_q <= sap_det && (std_q == STD_PILOT);
    end

    snd_router #(.SMP_W(SMP_W)) u_route (
        .std        (std_q),
        .mode       (mode_acc),
        .dig_use    (dig_use),
        .sap_on     (sap_q),
        .carrier_ok (carrier_ok),
        .pri        (pri_smp),
        .sec        (sec_smp),
        .sap        (sap_smp),
        .dga        (dga_smp),
        .dgb        (dgb_smp),
        .out_l      (rl),
        .out_r      (rr)
    );

    always_comb begin
        stat_n.std      = std_q;
        stat_n.mode     = mode_acc;
        stat_n.dig      = dig_use;
        stat_n.sap      = sap_q;
        stat_n.mute_pri = !carrier_ok[0];
        stat_n.mute_sec = !carrier_ok[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            status_irq <= 1'b0;
        end else begin
            stat_q     <= stat_n;
            status_irq <= (stat_n != stat_q);
        end
    end

    assign status  = stat_q;
    assign cur_std = std_q;
    assign src0_l  = rl[0];
    assign src0_r  = rr[0];
    assign src1_l  = rl[1];
    assign src1_r  = rr[1];
    assign src3_l  = rl[2];
    assign src3_r  = rr[2];
    assign src4_l  = rl[3];
    assign src4_r  = rr[3];
endmodule

// File: rtl/snd_auto_select_chk.sv
module snd_auto_select_chk #(
    parameter int unsigned SMP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cur_std,
    input logic [7:0]       status,
    input logic             status_irq,
    input logic             hop_req,
    input logic [1:0]       carrier_ok,
    input logic [SMP_W-1:0] src0_l,
    input logic [SMP_W-1:0] src0_r
);
    // R3: a hop request follows a swap between the two partner standards
    assert_hop_partner_R3: assert property (@(posedge clk) disable iff (rst)
        hop_req |-> ((cur_std == 2'd1 && $past(cur_std) == 2'd2) ||
                     (cur_std == 2'd2 && $past(cur_std) == 2'd1)));

    // R2: channel 0 is analog mono in the FM-plus-digital standard
    assert_ch0_analog_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_std == 2'd2) |-> (src0_l == src0_r));

    // R10: a lost carrier is reported on the next cycle
    assert_mute_pri_R10: assert property (@(posedge clk) disable iff (rst)
        !carrier_ok[0] |=> status[6]);
    assert_mute_sec_R10: assert property (@(posedge clk) disable iff (rst)
        !carrier_ok[1] |=> status[7]);

    // R11: the change pulse coincides with every status change and nothing else
    assert_irq_on_change_R11: assert property (@(posedge clk) disable iff (rst)
        (status != $past(status)) |-> status_irq);
    assert_irq_only_change_R11: assert property (@(posedge clk) disable iff (rst)
        status_irq |-> (status != $past(status)));

    // R6: digital sound is only reported in the FM-plus-digital standard
    assert_dig_std_R6: assert property (@(posedge clk) disable iff (rst)
        status[4] |-> (status[1:0] == 2'd2));

    // R9: the second program flag only appears in the pilot standard
    assert_sap_std_R9: assert property (@(posedge clk) disable iff (rst)
        status[5] |-> (status[1:0] == 2'd3));
endmodule

bind snd_auto_select snd_auto_select_chk #(.SMP_W(SMP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cur_std    (cur_std),
    .status     (status),
    .status_irq (status_irq),
    .hop_req    (hop_req),
    .carrier_ok (carrier_ok),
    .src0_l     (src0_l),
    .src0_r     (src0_r)
);

// File: tb/test_snd_auto_select.sv
module test_snd_auto_select;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic std_load = 1'b0;
    logic [1:0] std_sel = '0;
    logic id_stereo = 1'b0;
    logic id_bilingual = 1'b0;
    logic dig_ok = 1'b0;
    logic [7:0] dig_err = '0;
    logic sap_det = 1'b0;
    logic [1:0] carrier_ok = 2'b11;
    logic [W-1:0] pri_smp = '0, sec_smp = '0, sap_smp = '0, dga_smp = '0, dgb_smp = '0;
    logic [W-1:0] src0_l, src0_r, src1_l, src1_r, src3_l, src3_r, src4_l, src4_r;
    logic [1:0] cur_std;
    logic [7:0] status;
    logic status_irq, hop_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    snd_auto_select i_snd_auto_select (
        .clk(clk), .rst(rst), .tick(tick), .std_load(std_load), .std_sel(std_sel),
        .id_stereo(id_stereo), .id_bilingual(id_bilingual), .dig_ok(dig_ok),
        .dig_err(dig_err), .sap_det(sap_det), .carrier_ok(carrier_ok),
        .pri_smp(pri_smp), .sec_smp(sec_smp), .sap_smp(sap_smp),
        .dga_smp(dga_smp), .dgb_smp(dgb_smp),
        .src0_l(src0_l), .src0_r(src0_r), .src1_l(src1_l), .src1_r(src1_r),
        .src3_l(src3_l), .src3_r(src3_r), .src4_l(src4_l), .src4_r(src4_r),
        .cur_std(cur_std), .status(status), .status_irq(status_irq), .hop_req(hop_req)
    );

    wire [8*W-1:0] got = {src0_l, src0_r, src1_l, src1_r, src3_l, src3_r, src4_l, src4_r};

    task automatic chk(input string req, input logic [8*W-1:0] act, input logic [8*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected layout from the requirements; order: ch0 L/R, ch1 L/R, ch3 L/R, ch4 L/R
    function automatic logic [8*W-1:0] exp_route(int s, int m, bit dg, bit sp, logic [1:0] c,
                                                 logic [W-1:0] a, b, sa, da, db);
        logic [W-1:0] p, q;
        logic [W-1:0] o [8];
        p = c[0] ? a : '0;
        q = c[1] ? b : '0;
        for (int k = 0; k < 8; k++) o[k] = p;
        if (s == 1) begin
            if (m == 1) begin
                for (int k = 1; k < 8; k += 2) o[k] = q;
            end else if (m == 2) begin
                o[1] = q; o[3] = q; o[6] = q; o[7] = q;
            end
        end else if (s == 2) begin
            if (dg) begin
                for (int k = 2; k < 8; k++) o[k] = da;
                if (m == 1) begin o[3] = db; o[5] = db; o[7] = db; end
                if (m == 2) begin o[3] = db; o[6] = db; o[7] = db; end
            end
        end else if (s == 3) begin
            if (m == 1) for (int k = 1; k < 8; k += 2) o[k] = q;
            if (sp) begin o[3] = sa; o[6] = sa; o[7] = sa; end
        end
        return {o[0], o[1], o[2], o[3], o[4], o[5], o[6], o[7]};
    endfunction

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic load_std(int s);
        @(negedge clk); std_sel = 2'(s); std_load = 1'b1;
        @(negedge clk); std_load = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_route(string req, int s, int m, bit dg, bit sp, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pri_smp = W'($urandom); sec_smp = W'($urandom); sap_smp = W'($urandom);
            dga_smp = W'($urandom); dgb_smp = W'($urandom);
            carrier_ok = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
            #1;
            chk(req, got, exp_route(s, m, dg, sp, carrier_ok, pri_smp, sec_smp, sap_smp, dga_smp, dgb_smp));
        end
        @(negedge clk); carrier_ok = 2'b11;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R13: reset state
        chk("R13 status", 128'(status), 128'(8'h00));
        chk("R13 std", 128'(cur_std), 128'(2'd0));
        chk("R13 pulses", 128'({hop_req, status_irq}), 128'(2'b00));
        check_route("R12 mono after reset", 0, 0, 0, 0, 6);

        // R3: hunting between partner standards
        load_std(1);
        chk("R3 loaded", 128'(cur_std), 128'(2'd1));
        ticks(5);
        chk("R3 before dwell", 128'(cur_std), 128'(2'd1));
        chk("R3 no hop yet", 128'(hop_req), 128'(1'b0));
        ticks(1);
        chk("R3 swapped", 128'(cur_std), 128'(2'd2));
        chk("R3 hop pulse", 128'(hop_req), 128'(1'b1));
        idle(1);
        chk("R3 hop one cycle", 128'(hop_req), 128'(1'b0));
        ticks(6);
        chk("R3 swapped back", 128'(cur_std), 128'(2'd1));

        // R5 / R4: stereo lock on dual-FM
        id_stereo = 1'b1;
        load_std(1);
        ticks(2);
        check_route("R5 not yet stable", 1, 0, 0, 0, 4);
        ticks(1);
        check_route("R5 stereo accepted", 1, 1, 0, 0, 8);
        ticks(10);
        chk("R4 hold standard", 128'(cur_std), 128'(2'd1));
        idle(2);
        chk("R11 status stereo", 128'(status), 128'(8'h05));
        id_bilingual = 1'b1;
        ticks(3);
        check_route("R1 two languages", 1, 2, 0, 0, 8);

        // R10 / R11: carrier mute and change pulse
        idle(2);
        chk("R11 irq quiet", 128'(status_irq), 128'(1'b0));
        @(negedge clk); carrier_ok = 2'b01;
        @(negedge clk);
        chk("R11 irq pulse", 128'(status_irq), 128'(1'b1));
        chk("R10 mute in status", 128'(status), 128'(8'h89));
        @(negedge clk);
        chk("R11 irq single", 128'(status_irq), 128'(1'b0));
        #1;
        chk("R10 secondary zeroed", got,
            exp_route(1, 2, 0, 0, 2'b01, pri_smp, sec_smp, sap_smp, dga_smp, dgb_smp));
        carrier_ok = 2'b11;

        // R5 / R8: pilot standard, toggling identification
        id_stereo = 1'b0; id_bilingual = 1'b1;
        load_std(3);
        for (int i = 1; i <= 6; i++) begin
            id_stereo = (i % 2 == 1);
            ticks(1);
        end
        id_stereo = 1'b1;
        ticks(2);
        check_route("R5 toggling rejected", 3, 0, 0, 0, 4);
        ticks(1);
        check_route("R8 pilot stereo", 3, 1, 0, 0, 8);
        chk("R8 no hunting", 128'(cur_std), 128'(2'd3));

        // R9: second program
        sap_det = 1'b1;
        ticks(1);
        check_route("R9 sap stereo", 3, 1, 0, 1, 8);
        idle(2);
        chk("R11 status sap", 128'(status), 128'(8'h27));
        id_stereo = 1'b0;
        ticks(3);
        check_route("R9 sap mono", 3, 0, 0, 1, 6);
        sap_det = 1'b0;

        // R7 / R6 / R2: digital sound with hysteresis
        id_bilingual = 1'b0; id_stereo = 1'b1; dig_ok = 1'b1; dig_err = 8'd10;
        load_std(2);
        ticks(3);
        check_route("R7 not yet recovered", 2, 1, 0, 0, 4);
        ticks(1);
        check_route("R7 digital stereo", 2, 1, 1, 0, 8);
        idle(2);
        chk("R11 status digital", 128'(status), 128'(8'h16));
        dig_err = 8'd70;
        ticks(5);
        check_route("R6 between thresholds stays", 2, 1, 1, 0, 4);
        dig_err = 8'd100;
        ticks(2);
        check_route("R6 at upper threshold stays", 2, 1, 1, 0, 4);
        dig_err = 8'd101;
        ticks(1);
        check_route("R6 fallback high error", 2, 1, 0, 0, 6);
        dig_err = 8'd70;
        ticks(5);
        check_route("R7 hysteresis band", 2, 1, 0, 0, 4);
        dig_err = 8'd40;
        ticks(5);
        check_route("R7 at lower threshold", 2, 1, 0, 0, 4);
        dig_err = 8'd39;
        ticks(2);
        dig_err = 8'd60;
        ticks(1);
        dig_err = 8'd39;
        ticks(3);
        check_route("R7 count restarted", 2, 1, 0, 0, 4);
        ticks(1);
        check_route("R7 recovered", 2, 1, 1, 0, 6);
        chk("R4 digital hold", 128'(cur_std), 128'(2'd2));
        dig_ok = 1'b0;
        ticks(1);
        check_route("R6 carrier lost", 2, 1, 0, 0, 6);
        dig_ok = 1'b1; dig_err = 8'd10; id_bilingual = 1'b1;
        ticks(4);
        check_route("R7 digital languages", 2, 2, 1, 0, 8);

        // R12: mono standard ignores identification
        load_std(0);
        chk("R12 loaded", 128'(cur_std), 128'(2'd0));
        ticks(3);
        check_route("R12 mono standard", 0, 2, 0, 0, 8);
        idle(2);
        chk("R12 cleared digital", 128'(status[4]), 128'(1'b0));

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule